// File: doc/BRIEF.md
# Strap-Addressed Banked Configuration Register Target

This block is a two-wire bus target (SMBus framing) that serves the configuration registers of a sixteen-channel device. It oversamples the clock and data lines with the system clock and finds START and STOP conditions. It shifts in the target address, a register pointer and data bytes, acknowledges what it accepts, and drives read data back on the open-drain data line. Its 7-bit address comes from two strap inputs. Each strap carries a four-level value already resolved to a 2-bit code. Both straps are captured once, right after reset.

The register space is banked. A single bank-select register, shared by all banks, sits at pointer 0xF0. It steers the window at pointers 0x00 to 0x07 either to the bank that applies to every channel or to the private bank of one channel. Every other pointer is reserved. A write is START, write address, pointer, one or more data bytes, STOP. A read first writes the pointer, then issues a repeated START with the read address and takes one byte.

Top module: `smb_bank_slave`

## Requirements
- R1: The target address is 0x18 + 4*strap_hi + strap_lo (strap codes 0..3 for the levels low, resistor-low, open, high), so it spans 0x18..0x27. An address byte whose upper 7 bits equal it is acknowledged by pulling SDA low in the ninth clock. Bit 0 of the address byte is 0 for a write and 1 for a read.
- R2: The straps are sampled once after reset is released. Later strap changes do not alter the address.
- R3: An address byte that does not match is not acknowledged. Every following byte up to the next START is also not acknowledged and changes no register.
- R4: In a write, the address, pointer and data bytes are each acknowledged. The data byte is stored at the pointed register.
- R5: Pointer 0xF0 is the bank-select register. Bit 4 = 1 selects the shared bank. Bit 4 = 0 selects the channel bank numbered by bits 3:0. A read of 0xF0 returns the selection with bits 7:5 at 0.
- R6: Each of the sixteen channel banks and the shared bank holds its own eight registers (pointers 0x00..0x07). A write through one selection leaves all other banks unchanged.
- R7: A read returns the pointed byte MSB first on SDA, starting after the acknowledge of the read address. After the eighth bit and the controller's acknowledge bit, the target leaves SDA released.
- R8: Writes to reserved pointers (all except 0x00..0x07 and 0xF0) are acknowledged and discarded. Reads of them return 0x00.
- R9: Each accepted data byte increments the pointer, so a second data byte in the same write lands at the next pointer.
- R10: A START in any state restarts address reception and drops a partly received byte. A STOP returns the target to idle.
- R11: After reset SDA is released, the selection is channel 0 and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_hi | input | 2 | Upper address strap code |
| strap_lo | input | 2 | Lower address strap code |

## Verification
A wrong bus state appears within one byte as a missing or unexpected acknowledge bit in the ninth clock. A wrong pointer or bank selection appears as a wrong value on the next single-byte read, so every write is paired with a read-back through the same bank selection. Sweeping every strap pair and every channel bank exposes address arithmetic or bank indexing faults on the first transaction that touches the affected address or bank.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_REG, ST_RACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_MACK, ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/smb_edge.sv
module smb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NUM_CH   = 16,
  parameter int REGS     = 8,
  parameter logic [7:0] SEL_ADDR = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int RW  = $clog2(REGS);
  localparam int NB  = NUM_CH + 1;
  localparam int BW  = $clog2(NB);

  logic [7:0]     mem [NB][REGS];
  logic           sel_shared;
  logic [CHW-1:0] sel_ch;
  logic [BW-1:0]  bank_idx;
  logic           is_win, is_sel;

  assign is_win   = addr < 8'(REGS);
  assign is_sel   = addr == SEL_ADDR;
  assign bank_idx = sel_shared ? BW'(NUM_CH) : BW'(sel_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_shared <= 1'b0;
      sel_ch     <= '0;
    end else if (we && is_sel) begin
      sel_shared <= wdata[CHW];
      sel_ch     <= wdata[CHW-1:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      logic hit;
      assign hit = we && is_win && (bank_idx == BW'(b)) && (addr[RW-1:0] == RW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem[b][r] <= 8'h00;
        else if (hit) mem[b][r] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (is_sel)      rdata = 8'({sel_shared, sel_ch});
    else if (is_win) rdata = mem[bank_idx][addr[RW-1:0]];
  end
endmodule

// File: rtl/smb_bank_slave.sv
module smb_bank_slave #(
  parameter int NUM_CH   = 16,
  parameter int REGS     = 8,
  parameter logic [7:0] SEL_ADDR  = 8'hF0,
  parameter logic [6:0] BASE_ADDR = 7'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo
);
  import smb_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_e st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, ptr_q, ptr_d, rdata;
  logic       oe_q, oe_d, rw_q, rw_d, wr_en;
  logic [6:0] addr_q;
  logic       lock_q;
  logic       rx_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  smb_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_regbank #(.NUM_CH(NUM_CH), .REGS(REGS), .SEL_ADDR(SEL_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .we(wr_en), .addr(ptr_q),
    .wdata(sh_q), .rdata(rdata)
  );

  // address straps captured once after reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      addr_q <= BASE_ADDR + 7'({strap_hi, strap_lo});
      lock_q <= 1'b1;
    end
  end

  assign rx_state = (st_q == ST_ADDR) || (st_q == ST_REG) || (st_q == ST_WDATA);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    ptr_d = ptr_q;
    oe_d  = oe_q;
    rw_d  = rw_q;
    wr_en = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (scl_rise && rx_state && cnt_q != 4'd8) begin
      sh_d  = {sh_q[6:0], sda_s};
      cnt_d = cnt_q + 4'd1;
    end else if (scl_fall) begin
      case (st_q)
        ST_ADDR: if (cnt_q == 4'd8) begin
          if (lock_q && sh_q[7:1] == addr_q) begin
            oe_d = 1'b1;
            rw_d = sh_q[0];
            st_d = ST_AACK;
          end else begin
            st_d = ST_IGNORE;
          end
        end
        ST_AACK: begin
          if (rw_q) begin
            sh_d  = rdata;
            oe_d  = ~rdata[7];
            cnt_d = 4'd1;
            st_d  = ST_RDATA;
          end else begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_REG;
          end
        end
        ST_REG: if (cnt_q == 4'd8) begin
          ptr_d = sh_q;
          oe_d  = 1'b1;
          st_d  = ST_RACK;
        end
        ST_RACK: begin
          oe_d  = 1'b0;
          cnt_d = '0;
          st_d  = ST_WDATA;
        end
        ST_WDATA: if (cnt_q == 4'd8) begin
          wr_en = 1'b1;
          oe_d  = 1'b1;
          st_d  = ST_WACK;
        end
        ST_WACK: begin
          oe_d  = 1'b0;
          cnt_d = '0;
          ptr_d = ptr_q + 8'd1;
          st_d  = ST_WDATA;
        end
        ST_RDATA: begin
          if (cnt_q == 4'd8) begin
            oe_d = 1'b0;
            st_d = ST_MACK;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            oe_d  = ~sh_q[6];
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_MACK: st_d = ST_IGNORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      oe_q  <= 1'b0;
      rw_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      oe_q  <= oe_d;
      rw_q  <= rw_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/smb_bank_slave_chk.sv
module smb_bank_slave_chk (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  start_det,
  input logic                  stop_det,
  input smb_pkg::slv_state_e   st_q,
  input logic                  lock_q,
  input logic [6:0]            addr_q
);
  import smb_pkg::*;

  // R1: captured address lies inside the strap range
  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (addr_q >= 7'h18 && addr_q <= 7'h27));

  // R2: once captured the address never moves
  p_addr_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(addr_q));

  // R3: an ignoring target never pulls SDA
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE || st_q == ST_IDLE) |-> !sda_oe);

  // R7: SDA drive only changes while SCL is low
  p_sda_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10: START restarts address reception, STOP goes idle
  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR && !sda_oe));

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> st_q == ST_IDLE);
endmodule

bind smb_bank_slave smb_bank_slave_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .st_q(st_q),
  .lock_q(lock_q), .addr_q(addr_q)
);

// File: tb/tb_smb_bank_slave.sv
module tb_smb_bank_slave;
  localparam int H = 10;

  logic       clk, rst_n, scl_m, sda_m;
  logic [1:0] strap_hi, strap_lo;
  logic       sda_oe;
  wire        sda_bus = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  smb_bank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_hi(strap_hi), .strap_lo(strap_lo)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] hi, logic [1:0] lo);
    strap_hi = hi; strap_lo = lo;
    scl_m = 1; sda_m = 1; rst_n = 0;
    tick(4);
    rst_n = 1;
    tick(8);
  endtask

  task automatic bstart();
    sda_m = 1; tick(H);
    scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic bstop();
    sda_m = 0; tick(H);
    scl_m = 1; tick(H);
    sda_m = 1; tick(H);
  endtask

  task automatic sbit(logic b);
    sda_m = b; tick(H);
    scl_m = 1; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1; tick(H);
    scl_m = 1; tick(H/2);
    b = sda_bus; tick(H/2);
    scl_m = 0; tick(2);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
  endtask

  task automatic probe(input logic [6:0] a, output bit ack);
    bstart();
    wbyte({a, 1'b0}, ack);
    bstop();
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] r,
                        input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bstart();
    wbyte({a, 1'b0}, a0);
    wbyte(r, a1);
    wbyte(d, a2);
    bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(input logic [6:0] a, input logic [7:0] r,
                        output logic [7:0] d, output bit released);
    bit ack;
    bstart();
    wbyte({a, 1'b0}, ack);
    wbyte(r, ack);
    bstart();
    wbyte({a, 1'b1}, ack);
    rbyte(d);
    sbit(1'b1);
    tick(4);
    released = !sda_oe;
    bstop();
  endtask

  initial begin
    bit ok, rel;
    logic [7:0] d;
    logic [6:0] me;

    // R11: reset state
    do_reset(2'd0, 2'd0);
    chk("R11 sda released", sda_oe, 0);
    rd_reg(7'h18, 8'hF0, d, rel);
    chk("R11 select reset", d, 8'h00);
    rd_reg(7'h18, 8'h00, d, rel);
    chk("R11 reg reset", d, 8'h00);

    // R1 / R3: every strap pair
    for (int c = 0; c < 16; c++) begin
      do_reset(2'(c >> 2), 2'(c & 3));
      probe(7'(8'h18 + c), ok);
      chk("R1 own address ack", ok, 1);
      probe(7'(8'h18 + c) ^ 7'h01, ok);
      chk("R3 other address nack", ok, 0);
    end

    // R2: strap change after capture has no effect
    do_reset(2'd2, 2'd1);
    me = 7'h21;
    strap_hi = 2'd0; strap_lo = 2'd0;
    tick(4);
    probe(me, ok);
    chk("R2 captured address kept", ok, 1);
    probe(7'h18, ok);
    chk("R2 new strap address ignored", ok, 0);

    // R4 / R6: fill every channel bank and the shared bank
    for (int c = 0; c < 16; c++) begin
      wr_reg(me, 8'hF0, 8'(c), ok);
      wr_reg(me, 8'h00, 8'(8'hA0 + c), ok);
      chk("R4 write acked", ok, 1);
    end
    wr_reg(me, 8'hF0, 8'h10, ok);
    wr_reg(me, 8'h00, 8'h5B, ok);
    for (int c = 0; c < 16; c++) begin
      wr_reg(me, 8'hF0, 8'(c), ok);
      rd_reg(me, 8'h00, d, rel);
      chk("R6 channel bank", d, 8'hA0 + c);
    end
    // R5: shared selection and select read-back
    wr_reg(me, 8'hF0, 8'hFF, ok);
    rd_reg(me, 8'hF0, d, rel);
    chk("R5 select read", d, 8'h1F);
    rd_reg(me, 8'h00, d, rel);
    chk("R5 shared bank", d, 8'h5B);

    // R7: read patterns, MSB first, then released
    wr_reg(me, 8'hF0, 8'h03, ok);
    wr_reg(me, 8'h05, 8'h81, ok);
    rd_reg(me, 8'h05, d, rel);
    chk("R7 read value", d, 8'h81);
    chk("R7 released after read", rel, 1);

    // R9: two data bytes in one write
    bstart();
    wbyte({me, 1'b0}, ok);
    wbyte(8'h02, ok);
    wbyte(8'h11, ok);
    wbyte(8'h22, ok);
    chk("R9 second byte acked", ok, 1);
    bstop();
    rd_reg(me, 8'h02, d, rel);
    chk("R9 first byte", d, 8'h11);
    rd_reg(me, 8'h03, d, rel);
    chk("R9 incremented pointer", d, 8'h22);

    // R8: reserved pointers
    wr_reg(me, 8'h40, 8'h99, ok);
    chk("R8 reserved write acked", ok, 1);
    rd_reg(me, 8'h40, d, rel);
    chk("R8 reserved read", d, 8'h00);
    rd_reg(me, 8'h08, d, rel);
    chk("R8 reserved read 08", d, 8'h00);
    rd_reg(me, 8'h00, d, rel);
    chk("R8 window untouched", d, 8'hA3);

    // R3: mismatched write leaves register alone
    bstart();
    wbyte({7'h18, 1'b0}, ok);
    chk("R3 address nack", ok, 0);
    wbyte(8'h00, ok);
    chk("R3 pointer nack", ok, 0);
    wbyte(8'h77, ok);
    chk("R3 data nack", ok, 0);
    bstop();
    rd_reg(me, 8'h00, d, rel);
    chk("R3 register unchanged", d, 8'hA3);

    // R10: START mid data byte, then a fresh write
    bstart();
    wbyte({me, 1'b0}, ok);
    wbyte(8'h05, ok);
    for (int i = 0; i < 4; i++) sbit(1'b0);
    bstart();
    wbyte({me, 1'b0}, ok);
    wbyte(8'h06, ok);
    wbyte(8'h3C, ok);
    bstop();
    rd_reg(me, 8'h05, d, rel);
    chk("R10 aborted byte dropped", d, 8'h81);
    rd_reg(me, 8'h06, d, rel);
    chk("R10 restarted write", d, 8'h3C);
    // R10: STOP inside address byte, then normal write
    bstart();
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    bstop();
    tick(H);
    chk("R10 idle after stop", sda_oe, 0);
    wr_reg(me, 8'h07, 8'h6E, ok);
    chk("R10 write after stop", ok, 1);
    rd_reg(me, 8'h07, d, rel);
    chk("R10 value after stop", d, 8'h6E);

    done = 1;
    summary();
  end
endmodule